// File: doc/BRIEF.md
# Parallel-Port Style Register Bus Slave

This block lets a host reach a byte-wide register space through a slow, software-driven interface patterned on an enhanced parallel port. The host toggles general-purpose pins to run each transfer. An 8-bit data path carries both addresses and data. Three active-low or level controls come in: an address strobe, a data strobe and a read-select. One handshake output, ready, goes back to the host. The host drives the strobes with no relation to the block clock, so all three controls pass through a two-stage synchronizer before the block acts on them.

An address-strobe cycle either loads the internal pointer from the bus or returns the pointer to the host. A data-strobe cycle reads or writes the register-file entry that the pointer selects. After a data cycle completes, the pointer steps forward by one, so the host can stream bytes with no new address cycle. The host may assert a strobe only while ready is low. It then waits for ready to rise and releases the strobe. It starts the next cycle only after ready falls again. The bus is presented to the block as separate pad-side input, output and output-enable signals.

Top module: `epp_reg_slave`

## Requirements
- R1: While reset is held and on its release, the pointer is 0x00, `host_ready` is low and `bus_oe` is low.
- R2: An address-strobe cycle with `host_rd_wr_n` low (write) loads the pointer from `bus_in`.
- R3: An address-strobe cycle with `host_rd_wr_n` high (read) presents the pointer on `bus_out` while `host_ready` is high.
- R4: A data-strobe cycle with `host_rd_wr_n` low stores `bus_in` into the register-file entry that the pointer selects.
- R5: A data-strobe cycle with `host_rd_wr_n` high presents the entry that the pointer selects on `bus_out` while `host_ready` is high.
- R6: Each completed data cycle, read or write, advances the pointer by exactly one. Address cycles leave it unchanged.
- R7: Advancing from 0xFF yields 0x00.
- R8: `host_ready` rises on the third clock edge after a strobe goes low at the pins. It falls on the third clock edge after the strobe is released.
- R9: `bus_oe` is high only while a read cycle's strobe is still held after acceptance. It stays low throughout write cycles.
- R10: If both strobes fall together, the cycle is handled as an address cycle. The register file is not written and the pointer does not advance.
- R11: An address write issued after a burst replaces the pointer. The next data cycle uses the loaded value, with no pending increment applied on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_astb_n | input | 1 | Address strobe from host, active low, asynchronous |
| host_dstb_n | input | 1 | Data strobe from host, active low, asynchronous |
| host_rd_wr_n | input | 1 | 1 = host reads, 0 = host writes, asynchronous |
| host_ready | output | 1 | Transfer complete handshake to host |
| bus_in | input | 8 | Byte from the data pads |
| bus_out | output | 8 | Byte to the data pads |
| bus_oe | output | 1 | Pad output enable for `bus_out` |

## Verification
A strobe edge reaches the controller after two synchronizer edges. The third edge registers the result, so `host_ready`, `bus_out` and `bus_oe` are due three edges after the host changes a strobe. The pointer increment lands on the same edge that drops ready. The bench drives every pin on a falling edge. It checks that ready is still low after two rising edges and high after the third, and it checks the release side the same way. Read data and the enable are sampled only in that window. Pointer effects are checked through later address-read cycles.

// File: rtl/epp_pkg.sv
// Package: shared types for the parallel-port style register slave.
// Assumes: a single clock domain after synchronization.
package epp_pkg;
    // Controller phase: waiting for a strobe, or holding a result for the host
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } epp_state_e;
endpackage

// File: rtl/epp_sync.sv
// Module: epp_sync
// Purpose: multi-stage synchronizer for slow asynchronous level inputs.
// Assumes: each bit is a quasi-static level; bits are independent.
module epp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift the raw level through STAGES flops, cleared on reset
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in[b]};
            end
            assign sync_out[b] = chain[LAST];
        end
    endgenerate
endmodule

// File: rtl/epp_regfile.sv
// Module: epp_regfile
// Purpose: generic register file with one write port and one combinational read port.
// Assumes: the depth is a power of two that the address fully decodes; contents are not reset.
module epp_regfile #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one entry per enabled cycle
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read the selected entry without latency
    assign rdata = mem[raddr];
endmodule

// File: rtl/epp_ctrl.sv
// Module: epp_ctrl
// Purpose: strobe/ready handshake controller that owns the pointer and the read latch.
// Assumes: strobes and read-select arrive synchronized and active high; the host holds
//          read-select and the bus stable while a strobe is asserted.
module epp_ctrl
    import epp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              astb,
    input  logic              dstb,
    input  logic              rd,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              rf_we,
    output logic [DATA_W-1:0] dout,
    output logic              oe,
    output logic              ready
);
    localparam logic [ADDR_W-1:0] PTR_MAX = {ADDR_W{1'b1}};

    epp_state_e        state_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [DATA_W-1:0] dout_q;
    logic              ready_q;
    logic              op_rd_q;
    logic              op_data_q;
    logic              any_stb;
    logic              advance;

    assign any_stb = astb | dstb;
    // Pointer advances when a data cycle's strobe is released
    assign advance = (state_q == ST_HOLD) && !any_stb && op_data_q;
    // Register file write only on an accepted data write with no address strobe
    assign rf_we   = (state_q == ST_IDLE) && !astb && dstb && !rd;

    // Accept a strobe, perform the access, hold the result until release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ptr_q     <= '0;
            dout_q    <= '0;
            ready_q   <= 1'b0;
            op_rd_q   <= 1'b0;
            op_data_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (astb) begin
                        op_data_q <= 1'b0;
                        op_rd_q   <= rd;
                        if (rd) dout_q <= DATA_W'(ptr_q);
                        else    ptr_q  <= ADDR_W'(din);
                        ready_q   <= 1'b1;
                        state_q   <= ST_HOLD;
                    end else if (dstb) begin
                        op_data_q <= 1'b1;
                        op_rd_q   <= rd;
                        if (rd) dout_q <= rf_rdata;
                        ready_q   <= 1'b1;
                        state_q   <= ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (!any_stb) begin
                        ready_q <= 1'b0;
                        if (advance) ptr_q <= ptr_q + 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ptr   = ptr_q;
    assign dout  = dout_q;
    assign ready = ready_q;
    // Drive the pads only during a held read strobe
    assign oe    = (state_q == ST_HOLD) && op_rd_q && any_stb;

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (ptr_q == '0 && !ready_q)); // R1
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && ptr_q != PTR_MAX) |=> ptr_q == $past(ptr_q) + 1'b1); // R6
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && ptr_q == PTR_MAX) |=> ptr_q == '0); // R7
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q && !any_stb) |=> !ready_q); // R8
    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (rd && ready_q)); // R9
    AST_BOTH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (astb && dstb) |-> !rf_we); // R10
endmodule

// File: rtl/epp_reg_slave.sv
// Module: epp_reg_slave (top)
// Purpose: register bus slave for a host that bit-bangs a parallel-port style handshake.
// Assumes: host strobes are active low and asynchronous; pads are split into in/out/enable.
module epp_reg_slave #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_astb_n,
    input  logic              host_dstb_n,
    input  logic              host_rd_wr_n,
    output logic              host_ready,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);
    localparam int CTRL_BITS = 3;

    logic [CTRL_BITS-1:0] raw_ctrl;
    logic [CTRL_BITS-1:0] sync_ctrl;
    logic [ADDR_W-1:0]    ptr;
    logic                 rf_we;
    logic [DATA_W-1:0]    rf_rdata;

    // Present the controls active high before synchronizing
    assign raw_ctrl = {~host_astb_n, ~host_dstb_n, host_rd_wr_n};

    epp_sync #(
        .WIDTH  (CTRL_BITS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_ctrl),
        .sync_out (sync_ctrl)
    );

    epp_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .astb     (sync_ctrl[2]),
        .dstb     (sync_ctrl[1]),
        .rd       (sync_ctrl[0]),
        .din      (bus_in),
        .rf_rdata (rf_rdata),
        .ptr      (ptr),
        .rf_we    (rf_we),
        .dout     (bus_out),
        .oe       (bus_oe),
        .ready    (host_ready)
    );

    epp_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .waddr (ptr),
        .wdata (bus_in),
        .raddr (ptr),
        .rdata (rf_rdata)
    );

    AST_OE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> host_ready); // R9
endmodule

// File: tb/epp_reg_slave_bench.sv
module epp_reg_slave_bench;
    localparam logic [1:0] OP_AW = 2'd0, OP_AR = 2'd1, OP_DW = 2'd2, OP_DR = 2'd3;
    localparam int NVEC = 20;
    // {op, value to write, expected read}
    localparam logic [17:0] VEC [NVEC] = '{
        {OP_AW, 8'h10, 8'h00}, // R2
        {OP_AR, 8'h00, 8'h10}, // R3
        {OP_DW, 8'hAA, 8'h00}, // R4
        {OP_DW, 8'hBB, 8'h00}, // R4 R6
        {OP_AR, 8'h00, 8'h12}, // R6
        {OP_AW, 8'h10, 8'h00},
        {OP_DR, 8'h00, 8'hAA}, // R5
        {OP_DR, 8'h00, 8'hBB}, // R5 R6
        {OP_AR, 8'h00, 8'h12}, // R6
        {OP_AW, 8'hFE, 8'h00},
        {OP_DW, 8'h11, 8'h00},
        {OP_DW, 8'h22, 8'h00},
        {OP_AR, 8'h00, 8'h00}, // R7
        {OP_AW, 8'hFF, 8'h00},
        {OP_DR, 8'h00, 8'h22},
        {OP_AR, 8'h00, 8'h00}, // R7
        {OP_AW, 8'h20, 8'h00},
        {OP_DW, 8'h33, 8'h00},
        {OP_AW, 8'h20, 8'h00}, // R11
        {OP_DR, 8'h00, 8'h33}  // R11
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       astb_n = 1'b1;
    logic       dstb_n = 1'b1;
    logic       rd_wr_n = 1'b0;
    logic [7:0] bin = 8'h00;
    logic       ready;
    logic [7:0] bout;
    logic       boe;
    int         n_chk = 0;
    int         n_bad = 0;
    logic       finished = 1'b0;

    always #4 clk = ~clk;

    epp_reg_slave u_epp_reg_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_astb_n  (astb_n),
        .host_dstb_n  (dstb_n),
        .host_rd_wr_n (rd_wr_n),
        .host_ready   (ready),
        .bus_in       (bin),
        .bus_out      (bout),
        .bus_oe       (boe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One host cycle; strobes change on falling edges, results checked on the third edge
    task automatic xfer(input logic use_a, input logic use_d, input logic rd,
                        input logic [7:0] wv, output logic [7:0] rv);
        @(negedge clk);
        rd_wr_n = rd;
        bin = wv;
        @(negedge clk);
        astb_n = !use_a;
        dstb_n = !use_d;
        repeat (2) @(negedge clk);
        chk("R8 ready low before third edge", {7'd0, ready}, 8'd0);
        @(negedge clk);
        chk("R8 ready high on third edge", {7'd0, ready}, 8'd1);
        chk("R9 enable follows read select", {7'd0, boe}, {7'd0, rd});
        rv = bout;
        astb_n = 1'b1;
        dstb_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 ready held until third edge", {7'd0, ready}, 8'd1);
        @(negedge clk);
        chk("R8 ready low after release", {7'd0, ready}, 8'd0);
        chk("R9 enable low after release", {7'd0, boe}, 8'd0);
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {7'd0, ready}, 8'd0);
        chk("R1 enable in reset", {7'd0, boe}, 8'd0);
        rst_n = 1'b1;
        xfer(1'b1, 1'b0, 1'b1, 8'h00, r);
        chk("R1 pointer after reset", r, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            op = VEC[i][17:16];
            xfer(op == OP_AW || op == OP_AR, op == OP_DW || op == OP_DR,
                 op == OP_AR || op == OP_DR, VEC[i][15:8], r);
            if (op == OP_AR) chk("R3 R6 R7 R11 pointer readback", r, VEC[i][7:0]);
            if (op == OP_DR) chk("R5 R4 R11 data readback", r, VEC[i][7:0]);
        end

        // R10: both strobes together act as an address write
        xfer(1'b1, 1'b0, 1'b0, 8'h05, r);
        xfer(1'b0, 1'b1, 1'b0, 8'h77, r);
        xfer(1'b1, 1'b0, 1'b0, 8'h05, r);
        xfer(1'b1, 1'b1, 1'b0, 8'h09, r);
        xfer(1'b1, 1'b0, 1'b1, 8'h00, r);
        chk("R10 both strobes load pointer, no advance", r, 8'h09);
        xfer(1'b1, 1'b0, 1'b0, 8'h05, r);
        xfer(1'b0, 1'b1, 1'b1, 8'h00, r);
        chk("R10 entry untouched by dual strobe", r, 8'h77);

        // R2 address read does not advance pointer
        xfer(1'b1, 1'b0, 1'b0, 8'h40, r);
        xfer(1'b1, 1'b0, 1'b1, 8'h00, r);
        xfer(1'b1, 1'b0, 1'b1, 8'h00, r);
        chk("R2 R6 repeated pointer read", r, 8'h40);

        // R1 reset in mid-use clears pointer
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 ready during reset", {7'd0, ready}, 8'd0);
        rst_n = 1'b1;
        xfer(1'b1, 1'b0, 1'b1, 8'h00, r);
        chk("R1 pointer cleared by reset", r, 8'h00);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule